// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block holds the interrupt-enable register of a 16550-style serial port and works out, by fixed priority, the interrupt-identification byte that software reads to find out why the port interrupted. It takes a byte-wide register access interface and five level status inputs from the rest of the port: line-status error, receive data available, character timeout, transmit holding register empty, and modem status change. It drives one interrupt line.

The transmit-empty source is not a level. It is a pending latch. The latch sets when the holding register becomes empty, and it clears on its own set of events. One of these events is a read of the identification byte at the moment that source is the one reported. The other sources are levels owned by the neighbouring status logic. This block sends that logic a one-cycle clear strobe when software reads the register that acknowledges the source. The read-data output always presents the enable register at its address and the identification byte at its address, whether or not a read strobe is present. The register file mux outside the block uses this output, so it can look at the value without causing any side effect.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the identification byte reads 0x01 and the interrupt line is low.
- R2: A write to address 1 stores bits [3:0] only. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. Reading address 1 returns the stored bits with bits [7:4] at zero.
- R3: The identification byte reports the highest-priority source that is both enabled and pending, in bits [3:1]. The order from highest to lowest is: line status (011), receive data (010), transmit empty (001), modem status (000).
- R4: When no enabled source is pending, bit 0 of the identification byte is 1 and the interrupt line is low. Otherwise bit 0 is 0 and the line is high.
- R5: Bits [7:6] of the identification byte are 11 while the FIFO-enable input is high and 00 while it is low. Bits [5:4] are always 0.
- R6: In FIFO mode, a pending character timeout is reported at receive-data priority with bits [3:1] = 110. In non-FIFO mode bit 3 is always 0, so a timeout is reported as receive data (010).
- R7: The transmit-empty pending latch sets one cycle after the holding-empty status rises from 0 to 1.
- R8: A read of address 2 clears the transmit-empty latch only when transmit empty is the source reported in that cycle. A read of address 2 that reports any other source leaves the latch set.
- R9: A write to address 0 clears the transmit-empty latch. A write to address 1 loads the latch with the new transmit-empty enable bit ANDed with the holding-empty status.
- R10: In the same cycle as the access, a read of address 0 pulses the receive clear strobe, a read of address 5 pulses the line clear strobe and a read of address 6 pulses the modem clear strobe.
- R11: A write to address 2 leaves the identification byte and the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address (divisor latch access assumed off) |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Enable register at address 1, identification byte at address 2, zero elsewhere |
| st_line_err | input | 1 | Line-status error pending (level) |
| st_rx_avail | input | 1 | Received data available (level) |
| st_char_tmo | input | 1 | Character timeout pending (level) |
| st_thr_empty | input | 1 | Transmit holding register empty (level) |
| st_modem_chg | input | 1 | Modem status change pending (level) |
| fifo_en | input | 1 | FIFO mode selected by the FIFO control register |
| clr_rx | output | 1 | Receive buffer read, clears receive and timeout sources |
| clr_line | output | 1 | Line status read, clears the line source |
| clr_modem | output | 1 | Modem status read, clears the modem source |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that the holding-empty status is already at its idle value of 1 while reset is held, because the edge detector's history starts there. The stimulus keeps to both assumptions. Each step drives at most one strobe, and the bench raises the holding-empty input before it releases reset. Status inputs change only between clock edges. Random phases mix each status level with accesses to every address, so that priority ties and the clearing race between a latch edge and an identification read both occur.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned IER_W  = 4;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IER   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IIR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;

  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  typedef enum logic [2:0] {
    SRC_MODEM = 3'b000,
    SRC_THRE  = 3'b001,
    SRC_RX    = 3'b010,
    SRC_LINE  = 3'b011,
    SRC_TMO   = 3'b110
  } src_code_t;
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg #(
  parameter int unsigned IER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IER_W-1:0] wdata,
  output logic [IER_W-1:0] ier_o
);
  logic [IER_W-1:0] ier_q, ier_d;

  always_comb begin
    ier_d = ier_q;
    if (wr_en) ier_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  assign ier_o = ier_q;

  p_ier_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ier_q == $past(wdata)));
endmodule

// File: rtl/uart_thre_latch.sv
module uart_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic ier_wr_i,
  input  logic ier_bit_i,
  input  logic thr_wr_i,
  input  logic iir_rd_thre_i,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic prev_q;
  logic rise;

  assign rise = empty_i & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (ier_wr_i)                      pend_d = ier_bit_i & empty_i;
    else if (thr_wr_i | iir_rd_thre_i) pend_d = 1'b0;
    else if (rise)                     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      prev_q <= empty_i;
    end
  end

  assign pend_o = pend_q;

  p_thre_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(empty_i) && !ier_wr_i && !thr_wr_i && !iir_rd_thre_i) |=> pend_q);
  p_thre_iir_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_thre_i && !ier_wr_i) |=> !pend_q);
  p_thre_wr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !ier_wr_i) |=> !pend_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned IER_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [IER_W-1:0]  ier_i,
  input  logic              line_err_i,
  input  logic              rx_avail_i,
  input  logic              char_tmo_i,
  input  logic              thre_pend_i,
  input  logic              modem_chg_i,
  input  logic              fifo_en_i,
  output logic [DATA_W-1:0] iir_o,
  output logic              thre_shown_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = DATA_W - 4;

  src_code_t  code;
  logic       none;
  logic [HI_W-1:0] hi_bits;

  always_comb begin
    code         = SRC_MODEM;
    none         = 1'b0;
    thre_shown_o = 1'b0;
    if (ier_i[EN_LINE] && line_err_i) begin
      code = SRC_LINE;
    end else if (ier_i[EN_RX] && (rx_avail_i || char_tmo_i)) begin
      code = (char_tmo_i && fifo_en_i) ? SRC_TMO : SRC_RX;
    end else if (ier_i[EN_THRE] && thre_pend_i) begin
      code         = SRC_THRE;
      thre_shown_o = 1'b1;
    end else if (ier_i[EN_MODEM] && modem_chg_i) begin
      code = SRC_MODEM;
    end else begin
      none = 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < HI_W; g++) begin : g_hi
      if (g >= HI_W - 2) begin : g_fifo
        assign hi_bits[g] = fifo_en_i;
      end else begin : g_zero
        assign hi_bits[g] = 1'b0;
      end
    end
  endgenerate

  assign iir_o = {hi_bits, (none ? 3'b000 : code), none};
  assign irq_o = ~none;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned DW = uart_irq_pkg::DATA_W,
  parameter int unsigned AW = uart_irq_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          st_line_err,
  input  logic          st_rx_avail,
  input  logic          st_char_tmo,
  input  logic          st_thr_empty,
  input  logic          st_modem_chg,
  input  logic          fifo_en,
  output logic          clr_rx,
  output logic          clr_line,
  output logic          clr_modem,
  output logic          irq
);
  localparam int unsigned EW = uart_irq_pkg::IER_W;

  logic          sel_data, sel_ier, sel_iir, sel_lstat, sel_mstat;
  logic          ier_wr, thr_wr, iir_rd;
  logic [EW-1:0] ier;
  logic          thre_pend, thre_shown;
  logic [DW-1:0] iir;

  assign sel_data  = (reg_addr == AW'(A_DATA));
  assign sel_ier   = (reg_addr == AW'(A_IER));
  assign sel_iir   = (reg_addr == AW'(A_IIR));
  assign sel_lstat = (reg_addr == AW'(A_LSTAT));
  assign sel_mstat = (reg_addr == AW'(A_MSTAT));

  assign ier_wr = reg_wr & sel_ier;
  assign thr_wr = reg_wr & sel_data;
  assign iir_rd = reg_rd & sel_iir;

  uart_ier_reg #(.IER_W(EW)) u_ier (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ier_wr),
    .wdata (reg_wdata[EW-1:0]),
    .ier_o (ier)
  );

  uart_thre_latch u_thre (
    .clk           (clk),
    .rst_n         (rst_n),
    .empty_i       (st_thr_empty),
    .ier_wr_i      (ier_wr),
    .ier_bit_i     (reg_wdata[EN_THRE]),
    .thr_wr_i      (thr_wr),
    .iir_rd_thre_i (iir_rd & thre_shown),
    .pend_o        (thre_pend)
  );

  uart_irq_prio #(.IER_W(EW), .DATA_W(DW)) u_prio (
    .ier_i        (ier),
    .line_err_i   (st_line_err),
    .rx_avail_i   (st_rx_avail),
    .char_tmo_i   (st_char_tmo),
    .thre_pend_i  (thre_pend),
    .modem_chg_i  (st_modem_chg),
    .fifo_en_i    (fifo_en),
    .iir_o        (iir),
    .thre_shown_o (thre_shown),
    .irq_o        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ier)      reg_rdata = DW'(ier);
    else if (sel_iir) reg_rdata = iir;
  end

  assign clr_rx    = reg_rd & sel_data;
  assign clr_line  = reg_rd & sel_lstat;
  assign clr_modem = reg_rd & sel_mstat;

  p_line_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[EN_LINE] && st_line_err) |-> (iir[3:1] == 3'b011));
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((ier[EN_LINE] && st_line_err) || (ier[EN_RX] && (st_rx_avail || st_char_tmo)) ||
      (ier[EN_THRE] && thre_pend) || (ier[EN_MODEM] && st_modem_chg)) |-> (!irq && iir[0]));
  p_fifo_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (iir[7:6] == 2'b11));
  p_no_tmo_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!iir[3] && iir[7:6] == 2'b00));
  p_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_rx, clr_line, clr_modem}));
  p_iir_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_iir) |=> $stable(ier));
endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       st_line_err, st_rx_avail, st_char_tmo, st_thr_empty, st_modem_chg, fifo_en;
  logic       clr_rx, clr_line, clr_modem, irq;

  int n_checks = 0;
  int n_bad = 0;

  int   m_ier;
  bit   m_pend;
  bit   m_prev;

  always #2 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_line_err(st_line_err),
    .st_rx_avail(st_rx_avail), .st_char_tmo(st_char_tmo), .st_thr_empty(st_thr_empty),
    .st_modem_chg(st_modem_chg), .fifo_en(fifo_en), .clr_rx(clr_rx), .clr_line(clr_line),
    .clr_modem(clr_modem), .irq(irq)
  );

  function automatic logic [7:0] model_iir();
    logic [7:0] v;
    if (m_ier[2] && st_line_err)                     v = 8'h06;
    else if (m_ier[0] && (st_rx_avail || st_char_tmo)) v = (st_char_tmo && fifo_en) ? 8'h0C : 8'h04;
    else if (m_ier[1] && m_pend)                     v = 8'h02;
    else if (m_ier[3] && st_modem_chg)               v = 8'h00;
    else                                             v = 8'h01;
    if (fifo_en) v = v | 8'hC0;
    return v;
  endfunction

  task automatic step(input logic [2:0] a, input logic r, input logic w,
                      input logic [7:0] d, input string tag);
    logic [7:0] e_iir, e_rd;
    logic [3:0] e_str, g_str;
    logic       e_irq;
    reg_addr = a; reg_rd = r; reg_wr = w; reg_wdata = d;
    #1;
    e_iir = model_iir();
    e_rd  = (a == 3'd1) ? 8'(m_ier) : (a == 3'd2) ? e_iir : 8'h00;
    e_irq = ~e_iir[0];
    e_str = {e_irq, r && a == 3'd0, r && a == 3'd5, r && a == 3'd6};
    g_str = {irq, clr_rx, clr_line, clr_modem};
    n_checks++;
    if (reg_rdata !== e_rd || g_str !== e_str) begin
      n_bad++;
      $display("FAIL %s: rdata=%h irq/strobes=%b expected rdata=%h irq/strobes=%b",
               tag, reg_rdata, g_str, e_rd, e_str);
    end
    @(posedge clk);
    if (w && a == 3'd1) begin
      m_ier  = int'(d[3:0]);
      m_pend = d[1] & st_thr_empty;
    end else if ((w && a == 3'd0) || (r && a == 3'd2 && e_iir[3:0] == 4'h2)) begin
      m_pend = 1'b0;
    end else if (st_thr_empty && !m_prev) begin
      m_pend = 1'b1;
    end
    m_prev = st_thr_empty;
    @(negedge clk);
  endtask

  task automatic set_st(input bit le, input bit rx, input bit tmo, input bit te,
                        input bit mc, input bit fe);
    st_line_err = le; st_rx_avail = rx; st_char_tmo = tmo;
    st_thr_empty = te; st_modem_chg = mc; fifo_en = fe;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_addr = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    set_st(0, 0, 0, 1, 0, 0);
    m_ier = 0; m_pend = 0; m_prev = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(3'd2, 0, 0, 8'h00, "R1 iir");
    step(3'd1, 0, 0, 8'h00, "R1 ier");
    // R2: only bits 3:0 stored; enabling transmit empty while empty loads latch (R9)
    step(3'd1, 0, 1, 8'hFF, "R2 write");
    step(3'd1, 0, 0, 8'h00, "R2 readback");
    step(3'd2, 0, 0, 8'h00, "R9 ier load shows thre");
    // R8: read of iir while thre shown clears it
    step(3'd2, 1, 0, 8'h00, "R8 read thre");
    step(3'd2, 0, 0, 8'h00, "R8 cleared");
    // R7: rising edge of empty status
    set_st(0, 0, 0, 0, 0, 0); step(3'd2, 0, 0, 8'h00, "R7 low");
    set_st(0, 0, 0, 1, 0, 0); step(3'd2, 0, 0, 8'h00, "R7 edge");
    step(3'd2, 0, 0, 8'h00, "R7 pending");
    // R8: iir read showing line status keeps the latch
    set_st(1, 0, 0, 1, 0, 0); step(3'd2, 1, 0, 8'h00, "R8 other source");
    set_st(0, 0, 0, 1, 0, 0); step(3'd2, 0, 0, 8'h00, "R8 latch kept");
    // R9: holding register write clears
    step(3'd0, 0, 1, 8'h55, "R9 thr write");
    step(3'd2, 0, 0, 8'h00, "R9 cleared");
    // R3: priority ordering
    set_st(0, 0, 0, 0, 0, 0); step(3'd2, 0, 0, 8'h00, "R3 setup");
    set_st(1, 1, 0, 1, 1, 0); step(3'd2, 0, 0, 8'h00, "R3 all");
    set_st(0, 1, 0, 1, 1, 0); step(3'd2, 0, 0, 8'h00, "R3 rx");
    set_st(0, 0, 0, 1, 1, 0); step(3'd2, 0, 0, 8'h00, "R3 thre");
    step(3'd2, 1, 0, 8'h00, "R3 read thre");
    step(3'd2, 0, 0, 8'h00, "R3 modem");
    // R6/R5: timeout and fifo bits
    set_st(0, 0, 1, 1, 0, 1); step(3'd2, 0, 0, 8'h00, "R6 fifo timeout");
    set_st(0, 0, 1, 1, 0, 0); step(3'd2, 0, 0, 8'h00, "R6 no fifo");
    set_st(0, 0, 0, 1, 0, 1); step(3'd2, 0, 0, 8'h00, "R5 fifo idle");
    // R10: clear strobes
    step(3'd0, 1, 0, 8'h00, "R10 rbr");
    step(3'd5, 1, 0, 8'h00, "R10 lsr");
    step(3'd6, 1, 0, 8'h00, "R10 msr");
    // R11: write to iir address
    step(3'd2, 0, 1, 8'hFF, "R11 write");
    step(3'd2, 0, 0, 8'h00, "R11 after");
    step(3'd1, 0, 0, 8'h00, "R11 ier");
    // R4: nothing enabled, all pending
    step(3'd1, 0, 1, 8'h00, "R4 disable");
    set_st(1, 1, 1, 1, 1, 1); step(3'd2, 0, 0, 8'h00, "R4 masked");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic       r, w;
      int         k;
      set_st($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
      k = $urandom_range(0, 3);
      a = 3'($urandom_range(0, 7));
      r = (k == 1);
      w = (k == 2);
      step(a, r, w, 8'($urandom), "R3 random");
    end

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule